// File: doc/BRIEF.md
# Split-Bus Transaction Sequencer

This block bridges a narrow request bus onto a wide time-multiplexed bus. On the narrow side a requester presents address, write data and a read flag together and holds its request line until the block answers with an acknowledge. On the wide side the block acts as master. It sends the address and then the data over one shared 32-bit path. Each of these two phases has its own four-phase sync/acknowledge handshake.

In 16-bit mode every narrow cycle becomes one wide address-plus-data sequence. In 32-bit mode two consecutive 16-bit narrow cycles share one wide cycle:

- On a write, the first half is parked in a low-word latch, and the combined word goes out when the second half arrives.
- On a read, the first half triggers the wide read, and the upper half is parked in a high-word latch for the second narrow read.

The block reports the following for the most recent narrow cycle:

- the slave's BUSY and EMPTY bits;
- address and data acknowledge timeouts;
- read/write alignment errors between paired halves;
- a pending flag for a half-finished 32-bit pair.

Top module: `sbs_seq`

## Requirements
- R1: A wide transfer is an address phase followed by a data phase. `w_ds` is never high together with `w_as`, and `w_ds` rises only once `w_ak` has dropped after the address phase.
- R2: Each wide phase is a four-phase handshake. The sync line (`w_as` or `w_ds`) stays high until its acknowledge (`w_ak` or `w_dk`) rises or the timeout expires. The phase ends only after the acknowledge falls again.
- R3: `w_rd` (1 = read) accompanies the address. In a read data phase the block does not drive the path (`w_ad_oe` low), and narrow read data comes from `w_ad_in`.
- R4: The wide address is the narrow address, zero-extended and shifted right by 1 in 16-bit mode or by 2 in 32-bit mode.
- R5: In 16-bit mode (`n_is32`=0) every narrow cycle causes exactly one wide transfer. Write data goes out as {16'h0, `n_wdata`}, and a read returns bits 15:0 of the wide word.
- R6: In a 32-bit write pair, the first narrow write is acknowledged without any wide transfer. The second causes one wide write carrying {second word, first word}.
- R7: In a 32-bit read pair, the first narrow read causes one wide read and returns bits 15:0. The second narrow read returns bits 31:16 of that same word with no wide transfer.
- R8: `s_pend` is high from the acknowledge of a first 32-bit half until the matching second half completes. Reset and any error clear it.
- R9: An alignment error is raised when `s_pend` is set and the next request differs in read/write or is 16-bit. It gives `n_err`=1 and `s_align`=1 with no wide transfer, and clears `s_pend`.
- R10: The BUSY and EMPTY bits sampled with the data acknowledge appear on `s_busy` and `s_empty`, and `s_last` is high when both are set. None of them raises `n_err`.
- R11: If the address acknowledge never arrives within ADDR_TO cycles, the cycle ends with `n_err`=1 and `s_addr_to`=1. If the data acknowledge never arrives within DATA_TO cycles, it ends with `n_err`=1 and `s_data_to`=1.
- R12: `n_ack` stays high until `n_req` falls, and the status outputs are valid while `n_ack` is high. After reset `n_ack`, `n_err`, `w_as`, `w_ds` and `s_pend` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| n_req | input | 1 | Narrow request, held until acknowledge |
| n_rd | input | 1 | Narrow read (1) or write (0) |
| n_is32 | input | 1 | Narrow cycle is half of a 32-bit access |
| n_addr | input | NA_W | Narrow address |
| n_wdata | input | 16 | Narrow write data |
| n_ack | output | 1 | Narrow acknowledge |
| n_err | output | 1 | Cycle ended with an error |
| n_rdata | output | 16 | Narrow read data |
| w_as | output | 1 | Wide address sync |
| w_ds | output | 1 | Wide data sync |
| w_rd | output | 1 | Wide read flag sent with the address |
| w_ad_out | output | 32 | Wide address/data out |
| w_ad_oe | output | 1 | Block drives the wide path |
| w_ak | input | 1 | Wide address acknowledge |
| w_dk | input | 1 | Wide data acknowledge |
| w_ad_in | input | 32 | Wide read data |
| w_busy | input | 1 | Slave BUSY bit, sampled with the data acknowledge |
| w_empty | input | 1 | Slave EMPTY bit, sampled with the data acknowledge |
| s_pend | output | 1 | Second 32-bit half awaited |
| s_busy | output | 1 | BUSY of the last data phase |
| s_empty | output | 1 | EMPTY of the last data phase |
| s_last | output | 1 | BUSY and EMPTY together |
| s_addr_to | output | 1 | Address acknowledge timeout |
| s_data_to | output | 1 | Data acknowledge timeout |
| s_align | output | 1 | Read/write alignment error |

## Verification
Directed 16-bit reads and writes separate the one-transfer-per-cycle path from the paired path. Directed 32-bit write and read pairs show whether the latch holds the correct half, and whether the wide transfer count is one per pair rather than two. Mismatched halves, a 16-bit request while a pair is pending, and slaves that never acknowledge the address or the data each exercise a distinct error exit. Random mixes of size, direction, address and BUSY/EMPTY values stress back-to-back pairing against a bench model of the pending state.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_A_SYNC, ST_A_REL, ST_D_SYNC, ST_D_REL, ST_DONE
  } sbs_state_e;

  // wide word address from a narrow byte-lane address
  function automatic logic [31:0] wide_addr(input logic [31:0] nar, input logic is32);
    return is32 ? (nar >> 2) : (nar >> 1);
  endfunction

  // wide write word: paired halves or zero-extended single half
  function automatic logic [31:0] wide_wdata(input logic [15:0] cur, input logic [15:0] lo,
                                            input logic is32);
    return is32 ? {cur, lo} : {16'h0000, cur};
  endfunction
endpackage

// File: rtl/sbs_timer.sv
module sbs_timer #(
  parameter int ADDR_TO = 200,
  parameter int DATA_TO = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic sel_data,
  output logic expired
);
  localparam int MAXL = (ADDR_TO > DATA_TO) ? ADDR_TO : DATA_TO;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim     = sel_data ? CW'(DATA_TO - 1) : CW'(ADDR_TO - 1);
  assign expired = run && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) cnt <= '0;
    else if (cnt < lim)            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sbs_pair.sv
module sbs_pair (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lo_load,
  input  logic [15:0] lo_d,
  input  logic        hi_load,
  input  logic [15:0] hi_d,
  input  logic        is32,
  input  logic [15:0] cur_wdata,
  output logic [15:0] hi_q,
  output logic [31:0] wr_word
);
  import sbs_pkg::*;
  logic [15:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_load) lo_q <= lo_d;
      if (hi_load) hi_q <= hi_d;
    end
  end

  assign wr_word = wide_wdata(cur_wdata, lo_q, is32);
endmodule

// File: rtl/sbs_seq.sv
module sbs_seq #(
  parameter int NA_W    = 16,
  parameter int ADDR_TO = 200,
  parameter int DATA_TO = 150
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            n_req,
  input  logic            n_rd,
  input  logic            n_is32,
  input  logic [NA_W-1:0] n_addr,
  input  logic [15:0]     n_wdata,
  output logic            n_ack,
  output logic            n_err,
  output logic [15:0]     n_rdata,
  output logic            w_as,
  output logic            w_ds,
  output logic            w_rd,
  output logic [31:0]     w_ad_out,
  output logic            w_ad_oe,
  input  logic            w_ak,
  input  logic            w_dk,
  input  logic [31:0]     w_ad_in,
  input  logic            w_busy,
  input  logic            w_empty,
  output logic            s_pend,
  output logic            s_busy,
  output logic            s_empty,
  output logic            s_last,
  output logic            s_addr_to,
  output logic            s_data_to,
  output logic            s_align
);
  import sbs_pkg::*;

  sbs_state_e st, st_nx;
  logic            cur_rd, cur_is32, pend_rd;
  logic [NA_W-1:0] cur_addr;
  logic [15:0]     cur_wdata, hi_q;
  logic [31:0]     wr_word;

  // named events, also watched by the checker
  logic accept, align_evt, skip_wr, skip_rd, go_wide;
  logic tmo_hit, a_to_evt, d_to_evt, data_cap, hi_load, t_run, t_data;

  assign accept    = (st == ST_IDLE) && n_req;
  assign align_evt = accept && s_pend && ((n_rd != pend_rd) || !n_is32);
  assign skip_wr   = accept && !align_evt && n_is32 && !s_pend && !n_rd;
  assign skip_rd   = accept && !align_evt && n_is32 && s_pend && n_rd;
  assign go_wide   = accept && !align_evt && !skip_wr && !skip_rd;
  assign t_run     = (st == ST_A_SYNC) || (st == ST_A_REL) || (st == ST_D_SYNC) || (st == ST_D_REL);
  assign t_data    = (st == ST_D_SYNC) || (st == ST_D_REL);
  assign a_to_evt  = tmo_hit && !t_data;
  assign d_to_evt  = tmo_hit && t_data;
  assign data_cap  = (st == ST_D_SYNC) && w_dk;
  assign hi_load   = data_cap && cur_rd && cur_is32 && !s_pend;

  sbs_timer #(.ADDR_TO(ADDR_TO), .DATA_TO(DATA_TO)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(t_run), .restart(st_nx != st),
    .sel_data(t_data), .expired(tmo_hit));

  sbs_pair u_pair (
    .clk(clk), .rst_n(rst_n), .lo_load(skip_wr), .lo_d(n_wdata),
    .hi_load(hi_load), .hi_d(w_ad_in[31:16]), .is32(cur_is32),
    .cur_wdata(cur_wdata), .hi_q(hi_q), .wr_word(wr_word));

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (go_wide) st_nx = ST_A_SYNC; else if (accept) st_nx = ST_DONE;
      ST_A_SYNC: if (w_ak) st_nx = ST_A_REL;  else if (tmo_hit) st_nx = ST_DONE;
      ST_A_REL:  if (!w_ak) st_nx = ST_D_SYNC; else if (tmo_hit) st_nx = ST_DONE;
      ST_D_SYNC: if (w_dk) st_nx = ST_D_REL;  else if (tmo_hit) st_nx = ST_DONE;
      ST_D_REL:  if (!w_dk || tmo_hit) st_nx = ST_DONE;
      ST_DONE:   if (!n_req) st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      {cur_rd, cur_is32, pend_rd, s_pend, n_err} <= '0;
      {s_busy, s_empty, s_last, s_addr_to, s_data_to, s_align} <= '0;
      cur_addr <= '0; cur_wdata <= '0; n_rdata <= '0;
    end else begin
      st <= st_nx;
      if (accept) begin
        cur_rd <= n_rd; cur_is32 <= n_is32; cur_addr <= n_addr; cur_wdata <= n_wdata;
        {s_busy, s_empty, s_last, s_addr_to, s_data_to, s_align, n_err} <= '0;
      end
      if (align_evt) begin
        s_align <= 1'b1; n_err <= 1'b1; s_pend <= 1'b0;
      end
      if (skip_wr) begin
        s_pend <= 1'b1; pend_rd <= 1'b0;
      end
      if (skip_rd) begin
        n_rdata <= hi_q; s_pend <= 1'b0;
      end
      if (data_cap) begin
        s_busy <= w_busy; s_empty <= w_empty; s_last <= w_busy && w_empty;
        if (cur_rd) n_rdata <= w_ad_in[15:0];
        if (hi_load) begin
          s_pend <= 1'b1; pend_rd <= 1'b1;
        end else if (cur_is32) s_pend <= 1'b0;
      end
      if (st_nx == ST_DONE && st != ST_DONE && tmo_hit) begin
        n_err <= 1'b1; s_pend <= 1'b0;
        if (a_to_evt) s_addr_to <= 1'b1;
        if (d_to_evt) s_data_to <= 1'b1;
      end
    end
  end

  assign n_ack    = (st == ST_DONE);
  assign w_as     = (st == ST_A_SYNC);
  assign w_ds     = (st == ST_D_SYNC);
  assign w_rd     = cur_rd;
  assign w_ad_out = ((st == ST_A_SYNC) || (st == ST_A_REL)) ? wide_addr(32'(cur_addr), cur_is32) : wr_word;
  assign w_ad_oe  = (st == ST_A_SYNC) || ((st == ST_D_SYNC) && !cur_rd);
endmodule

// File: rtl/sbs_seq_chk.sv
module sbs_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic n_req,
  input logic n_ack,
  input logic n_err,
  input logic w_as,
  input logic w_ds,
  input logic w_ak,
  input logic w_dk,
  input logic w_rd,
  input logic w_ad_oe,
  input logic s_pend,
  input logic align_evt,
  input logic tmo_hit
);
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_as && w_ds)); // R1
  AST_DS_AFTER_AK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(w_ds) |-> !w_ak); // R1
  AST_AS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (w_as && !w_ak && !tmo_hit) |=> w_as); // R2
  AST_DS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ds && !w_dk && !tmo_hit) |=> w_ds); // R2
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ds && w_rd) |-> !w_ad_oe); // R3
  AST_ERR_CLR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (n_ack && n_err) |-> !s_pend); // R8
  AST_ALIGN_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    align_evt |=> (n_ack && n_err && !w_as)); // R9
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (n_ack && n_req) |=> n_ack); // R12
endmodule

bind sbs_seq sbs_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .n_req(n_req), .n_ack(n_ack), .n_err(n_err),
  .w_as(w_as), .w_ds(w_ds), .w_ak(w_ak), .w_dk(w_dk), .w_rd(w_rd),
  .w_ad_oe(w_ad_oe), .s_pend(s_pend), .align_evt(align_evt), .tmo_hit(tmo_hit));

// File: tb/sbs_seq_tb.sv
module sbs_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NA_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic n_req = 0, n_rd = 0, n_is32 = 0;
  logic [NA_W-1:0] n_addr = '0;
  logic [15:0] n_wdata = '0, n_rdata;
  logic n_ack, n_err, w_as, w_ds, w_rd, w_ad_oe;
  logic [31:0] w_ad_out;
  logic w_ak = 0, w_dk = 0, w_busy = 0, w_empty = 0;
  logic [31:0] w_ad_in = '0;
  logic s_pend, s_busy, s_empty, s_last, s_addr_to, s_data_to, s_align;

  logic mute_a = 0, mute_d = 0;
  logic [31:0] rec_addr = '0, rec_data = '0;
  logic rec_rd = 0;
  int wcyc = 0;
  int nvec = 0, nfail = 0;

  bit m_pend = 0, m_prd = 0;
  logic [15:0] m_lo = '0, m_hi = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbs_seq #(.NA_W(NA_W), .ADDR_TO(20), .DATA_TO(15)) u_dut (
    .clk(clk), .rst_n(rst_n), .n_req(n_req), .n_rd(n_rd), .n_is32(n_is32),
    .n_addr(n_addr), .n_wdata(n_wdata), .n_ack(n_ack), .n_err(n_err), .n_rdata(n_rdata),
    .w_as(w_as), .w_ds(w_ds), .w_rd(w_rd), .w_ad_out(w_ad_out), .w_ad_oe(w_ad_oe),
    .w_ak(w_ak), .w_dk(w_dk), .w_ad_in(w_ad_in), .w_busy(w_busy), .w_empty(w_empty),
    .s_pend(s_pend), .s_busy(s_busy), .s_empty(s_empty), .s_last(s_last),
    .s_addr_to(s_addr_to), .s_data_to(s_data_to), .s_align(s_align));

  // wide-bus slave model: acknowledges one cycle after each sync edge
  always @(posedge clk) begin
    if (!rst_n) begin
      w_ak <= 0; w_dk <= 0;
    end else begin
      if (w_as && !w_ak && !mute_a) begin
        w_ak <= 1; rec_addr <= w_ad_out; rec_rd <= w_rd; wcyc <= wcyc + 1;
      end else if (!w_as) w_ak <= 0;
      if (w_ds && !w_dk && !mute_d) begin
        w_dk <= 1;
        if (!w_rd) rec_data <= w_ad_out;
      end else if (!w_ds) w_dk <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_waddr(input logic [15:0] a, input bit is32);
    logic [31:0] z = {16'h0, a};
    return is32 ? {2'b00, z[31:2]} : {1'b0, z[31:1]};
  endfunction

  task automatic narrow_op(input bit rd, input bit is32, input logic [15:0] addr,
                           input logic [15:0] wd);
    int c0, waitc;
    bit e_cyc, e_err, e_al, e_ato, e_dto, e_data, chk_rd;
    logic [15:0] e_rdata;
    logic [31:0] e_wdata;
    e_cyc = 0; e_err = 0; e_al = 0; e_ato = 0; e_dto = 0; e_data = 0; chk_rd = 0;
    e_rdata = '0; e_wdata = '0;
    if (m_pend && (rd != m_prd || !is32)) begin
      e_err = 1; e_al = 1; m_pend = 0;
    end else if (is32 && !m_pend && !rd) begin
      m_lo = wd; m_pend = 1; m_prd = 0;
    end else if (is32 && m_pend && rd) begin
      e_rdata = m_hi; chk_rd = 1; m_pend = 0;
    end else if (mute_a) begin
      e_err = 1; e_ato = 1; m_pend = 0;
    end else if (mute_d) begin
      e_cyc = 1; e_err = 1; e_dto = 1; m_pend = 0;
    end else begin
      e_cyc = 1; e_data = 1;
      if (rd) begin
        e_rdata = w_ad_in[15:0]; chk_rd = 1;
        if (is32) begin m_hi = w_ad_in[31:16]; m_pend = 1; m_prd = 1; end
      end else begin
        e_wdata = is32 ? {wd, m_lo} : {16'h0, wd};
        if (is32) m_pend = 0;
      end
    end
    @(negedge clk);
    c0 = wcyc;
    n_rd = rd; n_is32 = is32; n_addr = addr; n_wdata = wd; n_req = 1;
    waitc = 0;
    do begin @(negedge clk); waitc++; end while (!n_ack && waitc < 500);
    chk(n_ack == 1, "R12 ack arrives", 32'(n_ack), 1);
    chk(n_err == e_err, "R9/R11 n_err", 32'(n_err), 32'(e_err));
    chk(wcyc - c0 == int'(e_cyc), "R5/R6/R7 wide transfer count", 32'(wcyc - c0), 32'(e_cyc));
    chk(s_pend == m_pend, "R8 pending flag", 32'(s_pend), 32'(m_pend));
    chk(s_align == e_al, "R9 align flag", 32'(s_align), 32'(e_al));
    chk(s_addr_to == e_ato, "R11 addr timeout flag", 32'(s_addr_to), 32'(e_ato));
    chk(s_data_to == e_dto, "R11 data timeout flag", 32'(s_data_to), 32'(e_dto));
    chk(s_busy == (e_data & w_busy), "R10 busy", 32'(s_busy), 32'(e_data & w_busy));
    chk(s_empty == (e_data & w_empty), "R10 empty", 32'(s_empty), 32'(e_data & w_empty));
    chk(s_last == (e_data & w_busy & w_empty), "R10 last", 32'(s_last), 32'(e_data & w_busy & w_empty));
    if (chk_rd) chk(n_rdata == e_rdata, "R3/R5/R7 read data", 32'(n_rdata), 32'(e_rdata));
    if (e_cyc) begin
      chk(rec_addr == exp_waddr(addr, is32), "R4 wide address", rec_addr, exp_waddr(addr, is32));
      chk(rec_rd == rd, "R3 read flag with address", 32'(rec_rd), 32'(rd));
    end
    if (e_data && !rd) chk(rec_data == e_wdata, "R5/R6 wide write data", rec_data, e_wdata);
    // R12: ack held while request stays up
    @(negedge clk);
    chk(n_ack == 1, "R12 ack held", 32'(n_ack), 1);
    n_req = 0;
    waitc = 0;
    do begin @(negedge clk); waitc++; end while (n_ack && waitc < 50);
    chk(n_ack == 0, "R12 ack released", 32'(n_ack), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(n_ack == 0 && n_err == 0, "R12 reset ack/err", {30'h0, n_ack, n_err}, 0);
    chk(w_as == 0 && w_ds == 0, "R12 reset syncs", {30'h0, w_as, w_ds}, 0);
    chk(s_pend == 0, "R8 reset pending", 32'(s_pend), 0);

    w_ad_in = 32'hCAFE_1234;
    narrow_op(0, 0, 16'h0102, 16'hA5A5);            // R5 write
    narrow_op(1, 0, 16'h0013, 16'h0);               // R5 read
    narrow_op(0, 1, 16'h0040, 16'h1111);            // R6 first
    narrow_op(0, 1, 16'h0042, 16'h2222);            // R6 second
    w_ad_in = 32'h8765_4321;
    narrow_op(1, 1, 16'h0080, 16'h0);               // R7 first
    w_ad_in = 32'h0;
    narrow_op(1, 1, 16'h0082, 16'h0);               // R7 second from latch
    narrow_op(0, 1, 16'h0100, 16'h3333);            // R9 setup
    narrow_op(1, 1, 16'h0102, 16'h0);               // R9 rw mismatch
    narrow_op(0, 1, 16'h0100, 16'h4444);            // R9 setup
    narrow_op(0, 0, 16'h0102, 16'h5555);            // R9 16-bit while pending
    w_busy = 1; w_empty = 1;
    narrow_op(1, 0, 16'h0200, 16'h0);               // R10 last
    w_busy = 1; w_empty = 0;
    narrow_op(0, 0, 16'h0202, 16'h6666);            // R10 busy only
    w_busy = 0;
    mute_a = 1;
    narrow_op(0, 0, 16'h0300, 16'h7777);            // R11 address timeout
    mute_a = 0; mute_d = 1;
    narrow_op(1, 1, 16'h0304, 16'h0);               // R11 data timeout, R8 cleared
    mute_d = 0;

    for (int i = 0; i < 300; i++) begin
      logic [2:0] r;
      r = 3'($urandom);
      w_ad_in = $urandom;
      w_busy = r[0]; w_empty = r[1];
      narrow_op(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule